// File: doc/BRIEF.md
# Switch-Programmable Sum-of-Products Array

This block is a small programmable logic array for four data inputs. Each input is offered to the array twice, once as it is and once inverted, so eight literal lines run past every product term. The array has four product terms. Each term is the AND of all eight literal lines, and each literal has its own switch bit. A switch that is on passes its literal to the term. A switch that is off holds that AND input at logic 1. A term with every switch off therefore reads 1.

Behind the AND plane sits a fixed OR plane. It forms the OR of every pair of product terms, which gives six results. The four raw product terms are also brought out, so the block has ten outputs in total. The 32 switch bits sit in a configuration register. A parallel word is written into that register on a synchronous load strobe, and an active-low reset clears it to all-off. The outputs depend only on the data inputs and the stored switches, with no clock between them. Clock edges change only the switch register.

Top module: `swpla_core`

## Requirements
- R1: Literal positions: within a term's 8-bit switch group, bit 2i enables data input i as it is, and bit 2i+1 enables data input i inverted (i = 0..3).
- R2: Product term t reads its switches from cfg_data bits [8t+7:8t]. It is 1 exactly when every literal whose switch is on is 1.
- R3: A product term with all eight switches off outputs 1, for any data input.
- R4: Fixed OR plane, in this output order: or_out[0]=P0|P1, or_out[1]=P1|P2, or_out[2]=P2|P3, or_out[3]=P0|P2, or_out[4]=P1|P3, or_out[5]=P0|P3, where Pt = prod_out[t].
- R5: The four product terms are driven straight out on prod_out[3:0], alongside the six OR results.
- R6: On a rising clk edge with cfg_load high, the register captures cfg_data. Without cfg_load the stored switches hold, whatever cfg_data does.
- R7: While rst_n is low the switches are all off, so every prod_out and or_out bit is 1.
- R8: A change on in_bits reaches prod_out and or_out with no clock edge in between.
- R9: Worked case: term 0 enables only input 0 as it is (bit 0) and term 1 enables only input 1 inverted (bit 11). Then (in_bits[0],in_bits[1]) = 00, 10, 01, 11 gives or_out[0] = 1, 1, 0, 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the switch register |
| rst_n | input | 1 | Asynchronous active-low reset; clears all switches to off |
| cfg_load | input | 1 | Load strobe for the switch register |
| cfg_data | input | 32 | Switch word, 8 bits per product term |
| in_bits | input | 4 | Data inputs |
| prod_out | output | 4 | Raw product terms |
| or_out | output | 6 | Pairwise ORs of the product terms |

## Verification
Some properties are checked at every clock edge. These are the capture of cfg_data under the strobe, the holding of the switches without it, the cleared register coming out of reset, every term with all switches off reading 1, and the six OR outputs agreeing with the product-term outputs in the stated pairing. Other behaviour only the bench scenarios can show. That covers whether each literal lands at its stated bit position, the full truth table under random switch words, the worked two-input case, and an input change appearing with no intervening clock edge. The bench checks these against a reference model over all sixteen input values.

// File: rtl/swpla_pkg.sv
package swpla_pkg;
    localparam int NUM_IN    = 4;
    localparam int NUM_TERMS = 4;
    localparam int LIT_W     = 2 * NUM_IN;
    localparam int CFG_W     = LIT_W * NUM_TERMS;
    localparam int NUM_PAIRS = NUM_TERMS * (NUM_TERMS - 1) / 2;

    // Pairs are ordered by term distance first, then by lower term index.
    function automatic int pair_lo(input int k, input int n);
        int idx;
        idx = 0;
        for (int d = 1; d < n; d++) begin
            for (int i = 0; i + d < n; i++) begin
                if (idx == k) return i;
                idx++;
            end
        end
        return 0;
    endfunction

    function automatic int pair_hi(input int k, input int n);
        int idx;
        idx = 0;
        for (int d = 1; d < n; d++) begin
            for (int i = 0; i + d < n; i++) begin
                if (idx == k) return i + d;
                idx++;
            end
        end
        return 0;
    endfunction
endpackage

// File: rtl/swpla_literals.sv
module swpla_literals #(
    parameter int N_IN = swpla_pkg::NUM_IN,
    localparam int L_W = 2 * N_IN
) (
    input  logic [N_IN-1:0] in_bits,
    output logic [L_W-1:0]  lit
);
    for (genvar i = 0; i < N_IN; i++) begin : g_pair
        assign lit[2*i]   = in_bits[i];
        assign lit[2*i+1] = ~in_bits[i];
    end
endmodule

// File: rtl/swpla_term.sv
module swpla_term #(
    parameter int L_W = swpla_pkg::LIT_W
) (
    input  logic [L_W-1:0] lit,
    input  logic [L_W-1:0] sw_on,
    output logic           prod
);
    logic [L_W-1:0] gated;
    always_comb begin
        for (int j = 0; j < L_W; j++) begin
            gated[j] = sw_on[j] ? lit[j] : 1'b1;
        end
        prod = &gated;
    end
endmodule

// File: rtl/swpla_or_plane.sv
module swpla_or_plane #(
    parameter int N_T = swpla_pkg::NUM_TERMS,
    localparam int N_P = N_T * (N_T - 1) / 2
) (
    input  logic [N_T-1:0] prod,
    output logic [N_P-1:0] sums
);
    for (genvar k = 0; k < N_P; k++) begin : g_pair
        localparam int LO = swpla_pkg::pair_lo(k, N_T);
        localparam int HI = swpla_pkg::pair_hi(k, N_T);
        assign sums[k] = prod[LO] | prod[HI];
    end
endmodule

// File: rtl/swpla_cfg_reg.sv
module swpla_cfg_reg #(
    parameter int W = swpla_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/swpla_core.sv
module swpla_core
    import swpla_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic [NUM_IN-1:0]    in_bits,
    output logic [NUM_TERMS-1:0] prod_out,
    output logic [NUM_PAIRS-1:0] or_out
);
    logic [CFG_W-1:0] cfg_q;
    logic [LIT_W-1:0] lit;

    swpla_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .d     (cfg_data),
        .q     (cfg_q)
    );

    swpla_literals #(.N_IN(NUM_IN)) u_lit (
        .in_bits (in_bits),
        .lit     (lit)
    );

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        swpla_term #(.L_W(LIT_W)) u_term (
            .lit   (lit),
            .sw_on (cfg_q[t*LIT_W +: LIT_W]),
            .prod  (prod_out[t])
        );
    end

    swpla_or_plane #(.N_T(NUM_TERMS)) u_or (
        .prod (prod_out),
        .sums (or_out)
    );
endmodule

// File: rtl/swpla_checker.sv
module swpla_checker
    import swpla_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic [CFG_W-1:0]     cfg_q,
    input  logic [NUM_TERMS-1:0] prod_out,
    input  logic [NUM_PAIRS-1:0] or_out
);
    p_load_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (cfg_q == $past(cfg_data)));

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_q));

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0));

    p_reset_outs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0) |-> (&prod_out && &or_out));

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_off
        p_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[t*LIT_W +: LIT_W] == '0) |-> prod_out[t]);
    end

    p_or_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        or_out == {prod_out[0] | prod_out[3], prod_out[1] | prod_out[3],
                   prod_out[0] | prod_out[2], prod_out[2] | prod_out[3],
                   prod_out[1] | prod_out[2], prod_out[0] | prod_out[1]});
endmodule

bind swpla_core swpla_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_data (cfg_data),
    .cfg_q    (cfg_q),
    .prod_out (prod_out),
    .or_out   (or_out)
);

// File: tb/swpla_core_bench.sv
module swpla_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_data = '0;
    logic [3:0]  in_bits = '0;
    logic [3:0]  prod_out;
    logic [5:0]  or_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    int edges    = 0;

    logic [9:0] exp_q[$];
    logic [9:0] mask_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    swpla_core u_swpla_core (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
        .in_bits(in_bits), .prod_out(prod_out), .or_out(or_out)
    );

    function automatic logic [3:0] ref_terms(input logic [31:0] cfg, input logic [3:0] x);
        logic [3:0] p;
        for (int t = 0; t < 4; t++) begin
            p[t] = 1'b1;
            for (int l = 0; l < 8; l++) begin
                logic litv;
                litv = l[0] ? ~x[l/2] : x[l/2];
                if (cfg[8*t+l] && !litv) p[t] = 1'b0;
            end
        end
        return p;
    endfunction

    function automatic logic [9:0] ref_all(input logic [31:0] cfg, input logic [3:0] x);
        logic [3:0] p;
        logic [5:0] r;
        p = ref_terms(cfg, x);
        r[0] = p[0] | p[1];
        r[1] = p[1] | p[2];
        r[2] = p[2] | p[3];
        r[3] = p[0] | p[2];
        r[4] = p[1] | p[3];
        r[5] = p[0] | p[3];
        return {r, p};
    endfunction

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            begin
                logic [9:0] e, m, got;
                string tg;
                e = exp_q.pop_front();
                m = mask_q.pop_front();
                tg = tag_q.pop_front();
                got = {or_out, prod_out};
                n_checks++;
                if ((got & m) !== (e & m)) begin
                    n_fails++;
                    $display("FAIL %s: actual %b expected %b (mask %b)", tg, got & m, e & m, m);
                end
            end
        end
    end

    task automatic push(input logic [9:0] e, input logic [9:0] m, input string tg);
        exp_q.push_back(e);
        mask_q.push_back(m);
        tag_q.push_back(tg);
        wait (exp_q.size() == 0);
    endtask

    task automatic load_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_data = v;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic drive_check(input logic [31:0] cfg, input logic [3:0] x, input string tg);
        @(negedge clk);
        in_bits = x;
        #1;
        push(ref_all(cfg, x), 10'h3FF, tg);
    endtask

    task automatic sweep(input logic [31:0] cfg, input string tg);
        for (int v = 0; v < 16; v++) drive_check(cfg, v[3:0], tg);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] cur;
        // R7: reset state, all outputs 1
        repeat (3) @(negedge clk);
        in_bits = 4'b1010;
        #1;
        push(10'h3FF, 10'h3FF, "R7 reset outputs");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        push(10'h3FF, 10'h3FF, "R7 after reset release");

        // R1: each literal position alone in term 0
        for (int l = 0; l < 8; l++) begin
            cur = 32'h1 << l;
            load_cfg(cur);
            sweep(cur, "R1 literal position");
        end

        // R2/R5: each term slice selects its own switches
        for (int t = 0; t < 4; t++) begin
            cur = 32'h0000_0005 << (8 * t);
            load_cfg(cur);
            sweep(cur, "R2 R5 term slice");
        end

        // R3: term 2 all off while others enabled
        cur = 32'h5A00_A5C3;
        load_cfg(cur);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            in_bits = v[3:0];
            #1;
            push(10'h004, 10'h004, "R3 all-off term");
        end

        // R9: worked two-input case on or_out[0]
        cur = 32'h0000_0801;
        load_cfg(cur);
        drive_check(cur, 4'b0000, "R9 case 00");
        push(10'h010, 10'h010, "R9 00 gives 1");
        drive_check(cur, 4'b0001, "R9 case 10");
        push(10'h010, 10'h010, "R9 10 gives 1");
        drive_check(cur, 4'b0010, "R9 case 01");
        push(10'h000, 10'h010, "R9 01 gives 0");
        drive_check(cur, 4'b0011, "R9 case 11");
        push(10'h010, 10'h010, "R9 11 gives 1");

        // R8: input change visible without a clock edge
        @(negedge clk);
        in_bits = 4'b0000;
        #1;
        begin
            int e0;
            e0 = edges;
            in_bits = 4'b0010;
            #1;
            push(ref_all(cur, 4'b0010), 10'h3FF, "R8 no-edge change");
            if (edges != e0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R8: actual %0d edges expected 0", edges - e0);
            end
        end

        // R6: cfg_data changes without load are ignored
        @(negedge clk);
        cfg_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        cfg_data = 32'h1234_5678;
        sweep(cur, "R6 hold without load");

        // R4: random configurations through the full OR plane
        for (int k = 0; k < 24; k++) begin
            cur = $urandom() & $urandom() & $urandom();
            load_cfg(cur);
            sweep(cur, "R4 R2 random config");
        end

        // R7: reset mid-run returns all outputs to 1
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int v = 0; v < 16; v += 5) begin
            in_bits = v[3:0];
            #1;
            push(10'h3FF, 10'h3FF, "R7 reset mid-run");
        end
        @(negedge clk);
        rst_n = 1'b1;
        sweep(32'h0, "R7 cleared config");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule